// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block is the device-side writer of a network receive path. Bytes of an incoming frame arrive one per cycle on a stream with a last marker and per-frame error and address-class qualifiers. The block stores each frame into a circular byte buffer through a 32-bit memory write port with byte enables. A four-byte header sits in front of each stored frame. The header carries a 16-bit status word in its low half and the frame length in its high half. The next frame starts at the following dword boundary.

The host consumes frames and hands its consumer position back through a pointer write. That value is always the true offset minus a fixed bias of 16. The block compares its own write offset against the recovered read offset to produce an empty flag. It drops any frame that would overrun unread data, and signals this with an overflow pulse. It signals a good frame with a receive-OK pulse, and a byte offered while it cannot take one with a FIFO-overflow pulse. The ring size is selected by a 2-bit index.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring size is `BASE_LEN << size_idx` for index 0, 1 and 2, and index 3 behaves as 2. All offsets run modulo that size.
- R2: Each accepted frame gets a header written in one cycle to its start offset: `mem_be` = 4'hF, `mem_wdata[15:0]` = status and `mem_wdata[31:16]` = length. The length is the number of stream bytes, FCS included.
- R3: The status bits are as follows. Bits 1 to 5 copy `in_err[0]` to `in_err[4]` (alignment, CRC, too long, runt, bad symbol). Bits 13, 14 and 15 copy `in_kind[0]` to `in_kind[2]` (broadcast, own address, multicast). Bit 0 is 1 exactly when `in_err` is zero. All other bits are 0.
- R4: After an accepted frame of length L starting at offset W, the write offset becomes (W + L + 4) rounded up to a multiple of 4, modulo the ring size.
- R5: A strobe on `rd_ptr_wr` sets the read offset to (`rd_ptr_val` + 16) modulo the ring size.
- R6: `empty` is 1 exactly when the read offset equals the write offset. After reset both offsets are 0.
- R7: Payload byte k of a frame starting at W is written at offset (W + 4 + k) modulo the ring size, so a frame that runs past the end continues at offset 0.
- R8: Let F be the free space: (read − write) modulo size, or the full size when empty. A payload byte k is written only if 4 + k < F. The whole frame is dropped if any byte was skipped or if its rounded total (L + 4 rounded up to 4) is not below F. A dropped frame writes no header, pulses `evt_ovf` in the header cycle and leaves the write offset unchanged.
- R9: The header is written in the cycle after the last byte is accepted. `in_ready` is 0 during that cycle. `empty` changes only together with the header write.
- R10: `evt_rx_ok` pulses together with the header write of a frame whose status bit 0 is 1. It never pulses for an errored or dropped frame.
- R11: A byte offered while `in_ready` is 0 is ignored and causes an `evt_fifo_ovf` pulse one cycle later.
- R12: A payload byte is written with a single byte enable `1 << addr[1:0]` and the byte copied into all four lanes of `mem_wdata`. Writes appear one cycle after the byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_idx | input | 2 | Ring size select |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of frame |
| in_err | input | 5 | Error qualifiers, sampled with last |
| in_kind | input | 3 | Address class qualifiers, sampled with last |
| in_ready | output | 1 | Block can accept a byte |
| rd_ptr_wr | input | 1 | Host read pointer write strobe |
| rd_ptr_val | input | 16 | Host read pointer, biased by −16 |
| empty | output | 1 | No unread frame in the ring |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | OFF_W | Byte offset in the ring |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| evt_rx_ok | output | 1 | Good frame stored pulse |
| evt_ovf | output | 1 | Frame dropped for lack of room pulse |
| evt_fifo_ovf | output | 1 | Byte offered while not ready pulse |

## Verification
Frames are sent with different lengths, error qualifiers and address classes. Lengths that are not multiples of four show whether the rounding of the next offset is right, and the qualifier mixes show whether each status bit lands in its own position. One frame straddles the end of the ring and shows whether the wrap is applied to payload only while the header stays at the old offset. A pair of frames whose rounded sizes land exactly at the free space and one byte short of it shows the strict overflow boundary. A case with a tiny free space shows that dropping suppresses every payload byte. A rerun with a larger size index shows that no wrap occurs at the smaller size.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int HDR_BYTES = 4;
  localparam int NUM_SIZES = 3;
  localparam int LEN_W     = 16;

  typedef enum logic {ST_DATA, ST_HDR} rx_st_e;

  // status: [15:13] address class, [5:1] error flags, [0] good frame
  function automatic logic [15:0] mk_status(input logic [4:0] err, input logic [2:0] kind);
    return {kind, 7'b0, err, (err == 5'd0)};
  endfunction
endpackage

// File: rtl/rxr_ptrs.sv
module rxr_ptrs
  import rxr_pkg::*;
#(
  parameter int BASE_LEN = 8192,
  parameter int RD_BIAS  = 16,
  parameter int OFF_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       size_idx,
  input  logic             rd_load,
  input  logic [15:0]      rd_val,
  input  logic             commit,
  input  logic [OFF_W-1:0] adv,
  output logic [OFF_W-1:0] wr_off,
  output logic [OFF_W-1:0] mask,
  output logic [OFF_W-1:0] free,
  output logic             empty
);
  logic [1:0]       idx_eff;
  logic [OFF_W-1:0] size;
  logic [OFF_W-1:0] rd_q, rd_d, wr_q, wr_d;

  always_comb begin
    idx_eff = (size_idx >= 2'(NUM_SIZES)) ? 2'(NUM_SIZES - 1) : size_idx;
    size    = OFF_W'(BASE_LEN) << idx_eff;
    mask    = size - 1'b1;
    rd_d    = (rd_val[OFF_W-1:0] + OFF_W'(RD_BIAS)) & mask;
    wr_d    = (wr_q + adv) & mask;
    empty   = (rd_q == wr_q);
    free    = empty ? size : ((rd_q - wr_q) & mask);
    wr_off  = wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (rd_load) rd_q <= rd_d;
      if (commit)  wr_q <= wr_d;
    end
  end

  p_wr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q[1:0] == 2'b00);
  p_commit_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !rd_load) |=> !empty);
  p_wr_in_ring_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q & ~mask) == '0);
endmodule

// File: rtl/rxr_frame.sv
module rxr_frame
  import rxr_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [4:0]       in_err,
  input  logic [2:0]       in_kind,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [OFF_W-1:0] mask,
  input  logic [OFF_W-1:0] free,
  output logic             in_ready,
  output logic             commit,
  output logic [OFF_W-1:0] adv,
  output logic             mem_we,
  output logic [OFF_W-1:0] mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  output logic             evt_rx_ok,
  output logic             evt_ovf,
  output logic             evt_fifo_ovf
);
  rx_st_e           st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic [15:0]      stat_q, stat_d;
  logic             drop_q, drop_d;
  logic             we_d, ok_d, ovf_d, fifo_d;
  logic [3:0]       be_d;
  logic [OFF_W-1:0] addr_d;
  logic [31:0]      wdata_d;
  logic             accept, fits, room, load_dat;
  logic [LEN_W:0]   rel, tot;
  logic [OFF_W-1:0] bpos;

  always_comb begin
    in_ready = (st_q == ST_DATA);
    accept   = in_valid & in_ready;
    rel      = {1'b0, cnt_q} + (LEN_W+1)'(HDR_BYTES);
    fits     = rel < (LEN_W+1)'(free);
    bpos     = (wr_off + OFF_W'(rel)) & mask;
    tot      = ({1'b0, len_q} + (LEN_W+1)'(HDR_BYTES + 3)) & ~(LEN_W+1)'(3);
    room     = tot < (LEN_W+1)'(free);
    commit   = (st_q == ST_HDR) & ~drop_q & room;
    adv      = tot[OFF_W-1:0];
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    stat_d  = stat_q;
    drop_d  = drop_q;
    we_d    = 1'b0;
    be_d    = '0;
    addr_d  = wr_off;
    wdata_d = {len_q, stat_q};
    ok_d    = 1'b0;
    ovf_d   = 1'b0;
    fifo_d  = in_valid & ~in_ready;
    if (st_q == ST_DATA) begin
      if (accept) begin
        if (fits) begin
          we_d    = 1'b1;
          be_d    = 4'b0001 << bpos[1:0];
          addr_d  = bpos;
          wdata_d = {4{in_data}};
        end
        drop_d = drop_q | ~fits;
        if (in_last) begin
          st_d   = ST_HDR;
          len_d  = cnt_q + 1'b1;
          stat_d = mk_status(in_err, in_kind);
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      st_d   = ST_DATA;
      drop_d = 1'b0;
      if (commit) begin
        we_d = 1'b1;
        be_d = 4'hF;
        ok_d = stat_q[0];
      end else begin
        ovf_d = 1'b1;
      end
    end
    load_dat = we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_DATA;
      cnt_q        <= '0;
      drop_q       <= 1'b0;
      mem_we       <= 1'b0;
      mem_be       <= '0;
      evt_rx_ok    <= 1'b0;
      evt_ovf      <= 1'b0;
      evt_fifo_ovf <= 1'b0;
    end else begin
      st_q         <= st_d;
      cnt_q        <= cnt_d;
      drop_q       <= drop_d;
      mem_we       <= we_d;
      mem_be       <= be_d;
      evt_rx_ok    <= ok_d;
      evt_ovf      <= ovf_d;
      evt_fifo_ovf <= fifo_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && in_last) begin
      len_q  <= len_d;
      stat_q <= stat_d;
    end
    if (load_dat) begin
      mem_addr  <= addr_d;
      mem_wdata <= wdata_d;
    end
  end

  p_hdr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 4'hF) |-> mem_addr[1:0] == 2'b00);
  p_one_lane_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'hF));
  p_hdr_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last) |=> !in_ready);
  p_ok_with_hdr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_ok |-> (mem_we && mem_be == 4'hF && !evt_ovf));
  p_drop_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |-> !mem_we);
  p_fifo_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> evt_fifo_ovf);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter  int BASE_LEN = 8192,
  parameter  int RD_BIAS  = 16,
  localparam int OFF_W    = $clog2(BASE_LEN * 4) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       size_idx,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [4:0]       in_err,
  input  logic [2:0]       in_kind,
  output logic             in_ready,
  input  logic             rd_ptr_wr,
  input  logic [15:0]      rd_ptr_val,
  output logic             empty,
  output logic             mem_we,
  output logic [OFF_W-1:0] mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  output logic             evt_rx_ok,
  output logic             evt_ovf,
  output logic             evt_fifo_ovf
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             commit;
  logic [OFF_W-1:0] adv, wr_off, mask, free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rxr_ptrs #(.BASE_LEN(BASE_LEN), .RD_BIAS(RD_BIAS), .OFF_W(OFF_W)) u_ptrs (
    .clk(clk), .rst_n(rst_int_n), .size_idx(size_idx),
    .rd_load(rd_ptr_wr), .rd_val(rd_ptr_val), .commit(commit), .adv(adv),
    .wr_off(wr_off), .mask(mask), .free(free), .empty(empty)
  );

  rxr_frame #(.OFF_W(OFF_W)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_err(in_err), .in_kind(in_kind),
    .wr_off(wr_off), .mask(mask), .free(free),
    .in_ready(in_ready), .commit(commit), .adv(adv),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .evt_rx_ok(evt_rx_ok), .evt_ovf(evt_ovf), .evt_fifo_ovf(evt_fifo_ovf)
  );
endmodule

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
  localparam int AW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] size_idx = 2'd0;
  logic in_valid = 1'b0, in_last = 1'b0, rd_ptr_wr = 1'b0;
  logic [7:0] in_data = '0;
  logic [4:0] in_err = '0;
  logic [2:0] in_kind = '0;
  logic [15:0] rd_ptr_val = '0;
  logic in_ready, empty, mem_we, evt_rx_ok, evt_ovf, evt_fifo_ovf;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;

  rx_ring_writer #(.BASE_LEN(256)) dut (
    .clk(clk), .rst_n(rst_n), .size_idx(size_idx), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_err(in_err), .in_kind(in_kind),
    .in_ready(in_ready), .rd_ptr_wr(rd_ptr_wr), .rd_ptr_val(rd_ptr_val),
    .empty(empty), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .evt_rx_ok(evt_rx_ok), .evt_ovf(evt_ovf),
    .evt_fifo_ovf(evt_fifo_ovf)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          drop;
    logic [AW-1:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    bit          ok;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int tests = 0, fails = 0;
  int wr_m = 0, rd_m = 0, size_m = 256;

  task automatic chk(input bit c, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected memory traffic as the design emits it
  always @(negedge clk) begin
    if (rst_n && (mem_we || evt_ovf)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8", {mem_we, evt_ovf, mem_addr}, 0);
      end else begin
        mon_e = q.pop_front();
        if (mon_e.drop) begin
          chk(!mem_we && evt_ovf, "R8", {mem_we, evt_ovf}, 2'b01);
        end else begin
          chk(mem_we && mem_addr == mon_e.addr && mem_be == mon_e.be && mem_wdata == mon_e.data,
              mon_e.tag, {mem_addr, mem_be, mem_wdata}, {mon_e.addr, mon_e.be, mon_e.data});
          if (mon_e.be == 4'hF)
            chk(evt_rx_ok == mon_e.ok && !evt_ovf, "R10", {evt_rx_ok, evt_ovf}, {mon_e.ok, 1'b0});
          else
            chk(!evt_rx_ok, "R12", evt_rx_ok, 0);
        end
      end
    end
  end

  task automatic send(input int len, input logic [4:0] err, input logic [2:0] kind,
                      input int seed, input bit extra, input string tag);
    int fr, tot, a;
    bit drp, emp0;
    logic [7:0] b;
    logic [15:0] st;
    fr   = (rd_m == wr_m) ? size_m : (rd_m - wr_m + size_m) % size_m;
    emp0 = (rd_m == wr_m);
    drp  = 1'b0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      b = 8'(seed + k);
      in_valid = 1'b1; in_data = b; in_last = (k == len - 1);
      in_err = err; in_kind = kind;
      if (4 + k < fr) begin
        a = (wr_m + 4 + k) % size_m;
        q.push_back('{1'b0, AW'(a), 4'(1 << (a % 4)), {4{b}}, 1'b0, tag});
      end else drp = 1'b1;
    end
    @(negedge clk);
    chk(empty == emp0, "R9", empty, emp0);
    chk(in_ready == 1'b0, "R9", in_ready, 0);
    tot = ((len + 7) / 4) * 4;
    st  = {kind, 7'b0, err, (err == 5'd0)};
    if (drp || tot >= fr) begin
      q.push_back('{1'b1, '0, '0, '0, 1'b0, tag});
    end else begin
      q.push_back('{1'b0, AW'(wr_m), 4'hF, {16'(len), st}, (err == 5'd0), tag});
      wr_m = (wr_m + tot) % size_m;
    end
    if (extra) begin in_valid = 1'b1; in_last = 1'b0; in_data = 8'hEE; end
    else in_valid = 1'b0;
    @(negedge clk);
    chk(evt_fifo_ovf == extra, "R11", evt_fifo_ovf, extra);
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    chk(empty == (rd_m == wr_m), "R6", empty, (rd_m == wr_m));
  endtask

  task automatic set_rd(input int off);
    @(negedge clk);
    rd_ptr_wr = 1'b1;
    rd_ptr_val = 16'(off - 16);
    @(negedge clk);
    rd_ptr_wr = 1'b0;
    rd_m = off;
    chk(empty == (rd_m == wr_m), "R5", empty, (rd_m == wr_m));
  endtask

  task automatic do_reset(input logic [1:0] idx, input int sz);
    @(negedge clk);
    rst_n = 1'b0; size_idx = idx;
    repeat (2) @(negedge clk);
    chk(empty == 1'b1 && mem_we == 1'b0, "R6", {empty, mem_we}, 2'b10);
    rst_n = 1'b1;
    wr_m = 0; rd_m = 0; size_m = sz;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset(2'd0, 256);
    send(10,  5'b00000, 3'b010, 8'h10, 1'b0, "R2");  // wr 0 -> 16
    send(7,   5'b00010, 3'b100, 8'h40, 1'b0, "R3");  // crc error, multicast; wr -> 28
    set_rd(28);
    send(200, 5'b00000, 3'b001, 8'h80, 1'b0, "R4");  // wr -> 232
    set_rd(232);
    send(40,  5'b00000, 3'b010, 8'h33, 1'b0, "R7");  // wraps, wr -> 20
    send(205, 5'b10000, 3'b000, 8'h01, 1'b0, "R8");  // total 212 == free 212: dropped
    send(204, 5'b00000, 3'b010, 8'h77, 1'b0, "R12"); // total 208 < 212: header at 20
    set_rd(228);
    send(5,   5'b00000, 3'b001, 8'hA0, 1'b1, "R11"); // stray byte while not ready
    set_rd(244);                                      // free 4: nothing fits
    send(3,   5'b00000, 3'b010, 8'h55, 1'b0, "R8");
    set_rd(240);
    do_reset(2'd1, 512);
    send(300, 5'b00000, 3'b010, 8'h22, 1'b0, "R1");  // no wrap at 256
    set_rd(304);
    do_reset(2'd3, 1024);
    send(600, 5'b00000, 3'b001, 8'h05, 1'b0, "R1");  // index 3 behaves as 2
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule